// File: doc/BRIEF.md
# Auto-Increment Lookup Table Loader

This block holds a bank of lighting lookup tables and fills them through a small register write bus. A configuration register picks which table is being loaded and the entry to start at. After that, software streams words into the table by writing to a data register. Every data write stores one entry and moves the entry pointer forward by one, so a whole table can be loaded with one configuration write followed by a burst of data writes. Eight consecutive bus addresses all act as the same data register, so a burst may use any of them in any mix.

Each stored entry carries two 12-bit unsigned fixed-point fields. The first is a sample value, where 4095 stands for 1.0. The second is a slope term that a later stage uses for interpolation. A separate read port, registered by one cycle, returns both fields of any table entry to the consumer. Writes aimed at a table number beyond the bank are dropped, while the pointer still advances. Reads of such a table number return zero.

Top module: `lut_loader`

## Requirements
- R1: A bus write to address 0 (the configuration register) loads the entry pointer from data bits [7:0] and the table number from data bits [12:8]. Data bits [31:13] have no effect.
- R2: A bus write to any address from 8 to 15 is a data write. All eight addresses have the same effect: data bits [23:0] are stored at the current table number and entry pointer.
- R3: After each data write, the entry pointer is one higher than before.
- R4: The entry pointer wraps from 255 to 0 and stays in the same table. The entry after 255 is entry 0 of the same table, not an entry of the next table.
- R5: Data bits [11:0] of a stored word come back on `rd_value` and bits [23:12] on `rd_diff`. Both fields pass unchanged, including the full-scale value 4095 that stands for 1.0. Data bits [31:24] are discarded.
- R6: The read port is registered. `rd_value` and `rd_diff` show the entry selected by `rd_table` and `rd_entry` at the previous rising clock edge, and hold it until the next edge.
- R7: There are 24 tables, numbered 0 to 23, each with 256 entries. A data write while the table number is 24 or higher changes no stored entry, but it still advances the entry pointer.
- R8: A read with `rd_table` of 24 or higher returns zero on both `rd_value` and `rd_diff`.
- R9: A configuration write takes effect for the data write in the very next cycle.
- R10: After synchronous reset, the table number and the entry pointer are both 0, and the read outputs are 0.
- R11: Bus writes to addresses 1 to 7 change neither the pointer, the table number nor any stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register address: 0 is configuration, 8 to 15 are the data aliases |
| bus_wdata | input | 32 | Write data |
| rd_table | input | 5 | Table number for the read port |
| rd_entry | input | 8 | Entry number for the read port |
| rd_value | output | 12 | Sample field of the selected entry, registered |
| rd_diff | output | 12 | Slope field of the selected entry, registered |

## Verification
On every cycle, the assertions check four things. A configuration write loads the pointer and the table number. Each data write adds exactly one to the pointer and keeps the table number. The storage never receives a write outside the bank. A read of a table number beyond the bank yields zero one cycle later. Only the bench scenarios can show the rest: that the eight aliases land in the right entries, that the pointer wraps inside one table, that dropped writes and writes to unused addresses leave stored entries untouched, and that the read port lags its address by one cycle.

// File: rtl/lutld_pkg.sv
package lutld_pkg;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int ALIAS_W    = 3;
    localparam int CFG_ADDR   = 0;
    localparam int DATA_BASE  = 8;
    localparam int IDX_W      = 8;
    localparam int TYPE_W     = 5;
    localparam int NUM_TABLES = 24;
    localparam int FIELD_W    = 12;
    localparam int ENTRY_W    = 2 * FIELD_W;
    localparam int FLAT_W     = TYPE_W + IDX_W;
    localparam int DEPTH      = NUM_TABLES << IDX_W;

    typedef struct packed {
        logic [FIELD_W-1:0] slope;
        logic [FIELD_W-1:0] sample;
    } lut_entry_t;

    typedef struct packed {
        logic [TYPE_W-1:0] table_no;
        logic [IDX_W-1:0]  index;
    } lut_ptr_t;

    function automatic logic table_ok(input logic [TYPE_W-1:0] t);
        return int'(t) < NUM_TABLES;
    endfunction

    function automatic logic [FLAT_W-1:0] flat_addr(input lut_ptr_t p);
        return {p.table_no, p.index};
    endfunction
endpackage

// File: rtl/lutld_decode.sv
module lutld_decode
    import lutld_pkg::*;
(
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              cfg_hit,
    output logic              data_hit
);
    localparam logic [ADDR_W-1:0]         CFG_A   = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-ALIAS_W-1:0] DATA_HI = (ADDR_W-ALIAS_W)'(DATA_BASE >> ALIAS_W);

    always_comb begin
        cfg_hit  = bus_we && (bus_addr == CFG_A);
        data_hit = bus_we && (bus_addr[ADDR_W-1:ALIAS_W] == DATA_HI);
    end
endmodule

// File: rtl/lutld_pointer.sv
module lutld_pointer
    import lutld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_hit,
    input  logic             data_hit,
    input  logic [BUS_W-1:0] wdata,
    output lut_ptr_t         ptr,
    output logic             store_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (cfg_hit) begin
            ptr.index    <= wdata[IDX_W-1:0];
            ptr.table_no <= wdata[IDX_W +: TYPE_W];
        end else if (data_hit) begin
            ptr.index <= ptr.index + 1'b1;
        end
    end

    always_comb store_en = data_hit && table_ok(ptr.table_no);

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_hit |=> (ptr.index == $past(wdata[IDX_W-1:0])) &&
                    (ptr.table_no == $past(wdata[IDX_W +: TYPE_W]))); // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (data_hit && !cfg_hit) |=> ptr.index == IDX_W'($past(ptr.index) + 1)); // R3
    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (data_hit && !cfg_hit) |=> $stable(ptr.table_no)); // R4
    AST_RST_PTR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr == '0); // R10
endmodule

// File: rtl/lutld_store.sv
module lutld_store
    import lutld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  lut_ptr_t          wr_ptr,
    input  logic [ENTRY_W-1:0] wr_word,
    input  lut_ptr_t          rd_ptr,
    output lut_entry_t        rd_q
);
    lut_entry_t mem [DEPTH];

    logic [FLAT_W-1:0] wr_flat;
    logic [FLAT_W-1:0] rd_flat;

    always_comb begin
        wr_flat = flat_addr(wr_ptr);
        rd_flat = flat_addr(rd_ptr);
    end

    always_ff @(posedge clk) begin
        if (store_en) begin
            mem[wr_flat] <= lut_entry_t'(wr_word);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (table_ok(rd_ptr.table_no)) begin
            rd_q <= mem[rd_flat];
        end else begin
            rd_q <= '0;
        end
    end

    AST_STORE_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        store_en |-> int'(wr_flat) < DEPTH); // R7
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !table_ok($past(rd_ptr.table_no)) |-> rd_q == '0); // R8
endmodule

// File: rtl/lut_loader.sv
module lut_loader
    import lutld_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [TYPE_W-1:0]  rd_table,
    input  logic [IDX_W-1:0]   rd_entry,
    output logic [FIELD_W-1:0] rd_value,
    output logic [FIELD_W-1:0] rd_diff
);
    logic       cfg_hit;
    logic       data_hit;
    logic       store_en;
    lut_ptr_t   cur_ptr;
    lut_ptr_t   rd_ptr;
    lut_entry_t rd_q;

    lutld_decode u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .cfg_hit  (cfg_hit),
        .data_hit (data_hit)
    );

    lutld_pointer u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cfg_hit  (cfg_hit),
        .data_hit (data_hit),
        .wdata    (bus_wdata),
        .ptr      (cur_ptr),
        .store_en (store_en)
    );

    always_comb begin
        rd_ptr.table_no = rd_table;
        rd_ptr.index    = rd_entry;
    end

    lutld_store u_mem (
        .clk      (clk),
        .rst      (rst),
        .store_en (store_en),
        .wr_ptr   (cur_ptr),
        .wr_word  (bus_wdata[ENTRY_W-1:0]),
        .rd_ptr   (rd_ptr),
        .rd_q     (rd_q)
    );

    always_comb begin
        rd_value = rd_q.sample;
        rd_diff  = rd_q.slope;
    end
endmodule

// File: tb/sim_lut_loader.sv
`timescale 1ns/1ps
module sim_lut_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [4:0]  rd_table = '0;
    logic [7:0]  rd_entry = '0;
    logic [11:0] rd_value;
    logic [11:0] rd_diff;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lut_loader u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_table(rd_table), .rd_entry(rd_entry),
        .rd_value(rd_value), .rd_diff(rd_diff)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] t, input logic [7:0] i, output logic [23:0] q);
        @(negedge clk);
        rd_table = t; rd_entry = i;
        @(posedge clk); #1;
        q = {rd_diff, rd_value};
    endtask

    function automatic logic [31:0] cfg(input int t, input int i);
        return (32'(t) << 8) | 32'(i & 255);
    endfunction

    task automatic t_reset();
        logic [23:0] q;
        #1;
        check("R10 read outputs after reset", {rd_diff, rd_value}, 24'h0);
        bus_wr(4'd8, 32'h0012_3456);
        rd(5'd0, 8'd0, q);
        check("R10 pointer starts at table 0 entry 0", q, 24'h12_3456);
    endtask

    task automatic t_burst();
        logic [23:0] q;
        bus_wr(4'd0, cfg(3, 10));
        bus_wr(4'd8,  32'hAB00_0FFF);
        bus_wr(4'd11, 32'h0080_0001);
        bus_wr(4'd15, 32'h00FF_F800);
        bus_wr(4'd9,  32'h0000_0000);
        rd(5'd3, 8'd10, q); check("R5 full scale 4095 kept, top byte dropped", q, 24'h00_0FFF);
        rd(5'd3, 8'd11, q); check("R3 second write at next entry", q, 24'h80_0001);
        rd(5'd3, 8'd12, q); check("R5 slope field returned", q, 24'hFF_F800);
        rd(5'd3, 8'd13, q); check("R3 fourth write at entry 13", q, 24'h00_0000);
    endtask

    task automatic t_alias();
        logic [23:0] q;
        bus_wr(4'd0, cfg(7, 100));
        for (int k = 0; k < 8; k++) bus_wr(4'(8 + k), 32'(24'h111111 * (k + 1)));
        for (int k = 0; k < 8; k++) begin
            rd(5'd7, 8'(100 + k), q);
            check($sformatf("R2 alias %0d", 8 + k), q, 24'(24'h111111 * (k + 1)));
        end
    endtask

    task automatic t_wrap();
        logic [23:0] q;
        bus_wr(4'd0, cfg(6, 0));
        bus_wr(4'd8, 32'h0066_0066);
        bus_wr(4'd0, cfg(5, 254));
        bus_wr(4'd8, 32'h0000_0AAA);
        bus_wr(4'd8, 32'h0000_0BBB);
        bus_wr(4'd8, 32'h0000_0CCC);
        rd(5'd5, 8'd255, q); check("R4 entry 255", q, 24'h00_0BBB);
        rd(5'd5, 8'd0, q);   check("R4 wrap lands in entry 0 of same table", q, 24'h00_0CCC);
        rd(5'd6, 8'd0, q);   check("R4 next table untouched by wrap", q, 24'h66_0066);
    endtask

    task automatic t_out_of_range();
        logic [23:0] q;
        bus_wr(4'd0, cfg(23, 40)); bus_wr(4'd8, 32'h0023_0040); bus_wr(4'd8, 32'h0023_0041);
        bus_wr(4'd0, cfg(0, 40));  bus_wr(4'd8, 32'h0000_0040); bus_wr(4'd8, 32'h0000_0041);
        bus_wr(4'd0, cfg(24, 40)); bus_wr(4'd8, 32'h00DE_AD01); bus_wr(4'd12, 32'h00DE_AD02);
        bus_wr(4'd0, cfg(31, 40)); bus_wr(4'd8, 32'h00BE_EF01);
        rd(5'd23, 8'd40, q); check("R7 table 23 entry 40 kept", q, 24'h23_0040);
        rd(5'd23, 8'd41, q); check("R7 table 23 entry 41 kept", q, 24'h23_0041);
        rd(5'd0, 8'd40, q);  check("R7 table 0 entry 40 kept", q, 24'h00_0040);
        rd(5'd0, 8'd41, q);  check("R7 table 0 entry 41 kept", q, 24'h00_0041);
        rd(5'd24, 8'd40, q); check("R8 read of table 24", q, 24'h0);
        rd(5'd31, 8'd0, q);  check("R8 read of table 31", q, 24'h0);
    endtask

    task automatic t_reconfig();
        logic [23:0] q;
        bus_wr(4'd0, cfg(9, 1));
        bus_wr(4'd8, 32'h0009_0001);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'hFFFF_E000 | cfg(2, 7);
        @(negedge clk);
        bus_addr = 4'd10; bus_wdata = 32'h0002_0007;
        @(negedge clk);
        bus_we = 1'b0;
        rd(5'd2, 8'd7, q); check("R9 write right after reconfig uses new pointer", q, 24'h02_0007);
        rd(5'd2, 8'd7, q); check("R1 upper config bits ignored", q, 24'h02_0007);
        rd(5'd9, 8'd1, q); check("R9 earlier table kept", q, 24'h09_0001);
    endtask

    task automatic t_unused();
        logic [23:0] q;
        bus_wr(4'd0, cfg(4, 20));
        bus_wr(4'd3, cfg(11, 90));
        bus_wr(4'd1, 32'h00FF_FFFF);
        bus_wr(4'd7, 32'h0012_0012);
        bus_wr(4'd8, 32'h0004_0020);
        rd(5'd4, 8'd20, q); check("R11 unused addresses leave pointer alone", q, 24'h04_0020);
    endtask

    task automatic t_latency();
        logic [23:0] q;
        rd(5'd3, 8'd11, q);
        check("R6 registered read shows entry", q, 24'h80_0001);
        @(negedge clk);
        rd_table = 5'd3; rd_entry = 8'd12;
        #1;
        check("R6 output holds before edge", {rd_diff, rd_value}, 24'h80_0001);
        @(posedge clk); #1;
        check("R6 output updates after edge", {rd_diff, rd_value}, 24'hFF_F800);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_burst();
        t_alias();
        t_wrap();
        t_out_of_range();
        t_reconfig();
        t_unused();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule